// File: doc/BRIEF.md
# Half-Bridge Fault and Reset Supervisor

This block holds the protection state for three half-bridges of a motor power stage. It takes each bridge's active-low reset line and each bridge's overcurrent shutdown request. It also takes a mode select, an over-temperature shutdown flag and an undervoltage flag. From these it drives one force-Hi-Z output per bridge and a single active-low fault output. The gate drivers use the force-Hi-Z outputs to turn off both switches of a bridge. A host or the motor controller watches the fault output.

The block sorts faults into three classes, and each class clears in its own way:

- **Per-bridge trip.** In cycle-by-cycle mode, an overcurrent request trips only its own bridge. A rising edge on that bridge's reset clears it.
- **Global latch.** In latching mode, an overcurrent request on any bridge latches a fault that turns off all bridges. An over-temperature shutdown does the same. This fault clears only after every bridge reset has risen while the cause is absent.
- **Undervoltage.** It turns off all bridges at once. It clears by itself when the flag drops, with no reset edge needed.

The power-on reset `rst_n` clears all fault state.

Each bridge runs a two-state machine:

- **CH_RUN to CH_TRIPPED:** a request arrives in cycle-by-cycle mode.
- **CH_TRIPPED to CH_RUN:** the bridge's reset rises while its request is low.

A shared machine handles the global latch:

- **GS_RUN to GS_LATCHED:** the hard condition (over-temperature, or a request in latching mode) is present.
- **GS_LATCHED back to GS_RUN:** the edge-seen mask is full.

The edge-seen mask records which resets have risen since the latch. It is cleared whenever the hard condition is present and whenever the machine returns to GS_RUN.

Top module: `hb_fault_supervisor`

## Requirements
- R1: While `chan_rst_n[i]` is low, `hiz[i]` is high in the same cycle, whatever the fault state.
- R2: With `latch_mode`=0, a high `chan_trip[i]` at a clock edge sets `hiz[i]` and drives `fault_n` low from that edge. Bit i of each vector is bridge i. Other bridges are not affected.
- R3: A tripped bridge i returns to normal at the clock edge that samples a rising edge of `chan_rst_n[i]` while `chan_trip[i]` is low. From that edge `hiz[i]` is low and `fault_n` is high. Rising edges on other bridges' resets leave the trip in place.
- R4: With `latch_mode`=1, a high `chan_trip` bit, or a high `otp_trip`, sets all `hiz` bits and drives `fault_n` low from that clock edge.
- R5: A global latch clears only at the edge that samples the last missing reset rise. The three resets may rise in any order and at any times. From that edge all `hiz` bits are low and `fault_n` is high.
- R6: A reset rise sampled while the hard condition is present does not count toward clearing. Any cycle with the hard condition present discards the rises collected so far.
- R7: A high `uv_flag` sets all `hiz` bits in the same cycle and drives `fault_n` low from the next edge. When the flag drops, the bits are released in the same cycle (given no other fault) and `fault_n` rises at the next edge. No reset edge is needed.
- R8: A low `rst_n` clears every latched fault. After it, `hiz` follows only the resets and `fault_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| latch_mode | input | 1 | 1: overcurrent latches globally; 0: cycle-by-cycle per bridge |
| chan_rst_n | input | NCH | Per-bridge reset, active low |
| chan_trip | input | NCH | Per-bridge overcurrent shutdown request |
| otp_trip | input | 1 | Over-temperature shutdown flag |
| uv_flag | input | 1 | Undervoltage flag on any supply |
| hiz | output | NCH | Per-bridge force-Hi-Z |
| fault_n | output | 1 | Registered fault output, active low |

## Verification
The assertions assume that every input is synchronous to `clk`, so each reset rise is seen on exactly one sampling edge. They also assume that `latch_mode` is static while a fault is held. The bench changes inputs only on falling clock edges and holds each reset low for at least a full cycle. It switches the mode only after all faults are clear.

// File: rtl/hbfs_pkg.sv
package hbfs_pkg;
    typedef enum logic {CH_RUN, CH_TRIPPED} ch_state_t;
    typedef enum logic {GS_RUN, GS_LATCHED} gl_state_t;
endpackage

// File: rtl/hbfs_rise.sv
module hbfs_rise #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q[i] <= 1'b1;
            else        prev_q[i] <= lvl[i];
        end
        assign rise[i] = lvl[i] & ~prev_q[i];
    end
endmodule

// File: rtl/hbfs_chan_fsm.sv
module hbfs_chan_fsm
    import hbfs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cbc_en,
    input  logic trip_req,
    input  logic rst_rise,
    output logic tripped,
    output logic tripped_nx
);
    ch_state_t st_q, st_nx;

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            CH_RUN:     if (cbc_en && trip_req) st_nx = CH_TRIPPED;
            CH_TRIPPED: if (rst_rise && !trip_req) st_nx = CH_RUN;
            default:    st_nx = CH_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CH_RUN;
        else        st_q <= st_nx;
    end

    always_comb begin
        tripped    = (st_q == CH_TRIPPED);
        tripped_nx = (st_nx == CH_TRIPPED);
    end

    // R2: a request in cycle-by-cycle mode trips the bridge at the next edge
    a_r2_trip_enters: assert property (@(posedge clk) disable iff (!rst_n)
        (cbc_en && trip_req) |=> tripped);
    // R3: without its own reset rise the bridge stays tripped
    a_r3_needs_own_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (tripped && !rst_rise) |=> tripped);
endmodule

// File: rtl/hbfs_global_fsm.sv
module hbfs_global_fsm
    import hbfs_pkg::*;
#(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hard_req,
    input  logic [N-1:0] rise,
    output logic         latched,
    output logic         latched_nx
);
    gl_state_t    st_q, st_nx;
    logic [N-1:0] seen_q, seen_nx;

    always_comb begin
        st_nx   = st_q;
        seen_nx = seen_q;
        unique case (st_q)
            GS_RUN: begin
                seen_nx = '0;
                if (hard_req) st_nx = GS_LATCHED;
            end
            GS_LATCHED: begin
                if (hard_req) begin
                    seen_nx = '0;
                end else begin
                    seen_nx = seen_q | rise;
                    if (&seen_nx) begin
                        st_nx   = GS_RUN;
                        seen_nx = '0;
                    end
                end
            end
            default: begin
                st_nx   = GS_RUN;
                seen_nx = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= GS_RUN;
            seen_q <= '0;
        end else begin
            st_q   <= st_nx;
            seen_q <= seen_nx;
        end
    end

    always_comb begin
        latched    = (st_q == GS_LATCHED);
        latched_nx = (st_nx == GS_LATCHED);
    end

    // R4: the hard condition latches at the next edge
    a_r4_latch_enters: assert property (@(posedge clk) disable iff (!rst_n)
        hard_req |=> latched);
    // R5: without every reset rise collected the latch holds
    a_r5_hold_until_all: assert property (@(posedge clk) disable iff (!rst_n)
        (latched && !(&(seen_q | rise))) |=> latched);
    // R6: the latch never clears while the condition is present
    a_r6_present_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (latched && hard_req) |=> (latched && seen_q == '0));
endmodule

// File: rtl/hb_fault_supervisor.sv
module hb_fault_supervisor #(
    parameter int NCH = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           latch_mode,
    input  logic [NCH-1:0] chan_rst_n,
    input  logic [NCH-1:0] chan_trip,
    input  logic           otp_trip,
    input  logic           uv_flag,
    output logic [NCH-1:0] hiz,
    output logic           fault_n
);
    logic [NCH-1:0] rst_rise;
    logic [NCH-1:0] ch_tripped, ch_tripped_nx;
    logic           hard_req, g_latched, g_latched_nx;
    logic           fault_n_q;

    assign hard_req = otp_trip | (latch_mode & (|chan_trip));

    hbfs_rise #(.N(NCH)) u_rise (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (chan_rst_n),
        .rise (rst_rise)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        hbfs_chan_fsm u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .cbc_en    (~latch_mode),
            .trip_req  (chan_trip[i]),
            .rst_rise  (rst_rise[i]),
            .tripped   (ch_tripped[i]),
            .tripped_nx(ch_tripped_nx[i])
        );

        assign hiz[i] = ~chan_rst_n[i] | ch_tripped[i] | g_latched | uv_flag;

        // R1: a low bridge reset always forces Hi-Z
        a_r1_rst_low_hiz: assert property (@(posedge clk) disable iff (!rst_n)
            !chan_rst_n[i] |-> hiz[i]);
    end

    hbfs_global_fsm #(.N(NCH)) u_glob (
        .clk       (clk),
        .rst_n     (rst_n),
        .hard_req  (hard_req),
        .rise      (rst_rise),
        .latched   (g_latched),
        .latched_nx(g_latched_nx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fault_n_q <= 1'b1;
        else        fault_n_q <= ~(g_latched_nx | (|ch_tripped_nx) | uv_flag);
    end

    assign fault_n = fault_n_q;

    // R7: undervoltage pulls the fault output low at the next edge
    a_r7_uv_fault: assert property (@(posedge clk) disable iff (!rst_n)
        uv_flag |=> !fault_n);
    // R4: over-temperature turns off every bridge from the next edge
    a_r4_otp_all_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        otp_trip |=> (&hiz));
endmodule

// File: tb/hb_fault_supervisor_tb.sv
module hb_fault_supervisor_tb;
    localparam int CLK_PER = 10;
    localparam int NCH     = 3;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           latch_mode;
    logic [NCH-1:0] chan_rst_n;
    logic [NCH-1:0] chan_trip;
    logic           otp_trip;
    logic           uv_flag;
    logic [NCH-1:0] hiz;
    logic           fault_n;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    hb_fault_supervisor #(.NCH(NCH)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .latch_mode(latch_mode),
        .chan_rst_n(chan_rst_n),
        .chan_trip (chan_trip),
        .otp_trip  (otp_trip),
        .uv_flag   (uv_flag),
        .hiz       (hiz),
        .fault_n   (fault_n)
    );

    always #(CLK_PER/2) clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_rst(input int i);
        chan_rst_n[i] = 1'b0;
        step();
        chan_rst_n[i] = 1'b1;
        step();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; latch_mode = 1'b0; chan_rst_n = '1;
        chan_trip = '0; otp_trip = 1'b0; uv_flag = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();
        chk("R8 reset hiz", 8'(hiz), 8'h0);
        chk("R8 reset fault_n", 8'(fault_n), 8'h1);
    endtask

    task automatic t_rst_hiz();
        chan_rst_n = 3'b101;
        #1 chk("R1 reset low forces hiz", 8'(hiz), 8'h2);
        chan_rst_n = '1;
        step();
        chk("R1 released", 8'(hiz), 8'h0);
    endtask

    task automatic t_cbc();
        chan_trip = 3'b001;
        step();
        chk("R2 trip hiz", 8'(hiz), 8'h1);
        chk("R2 trip fault_n", 8'(fault_n), 8'h0);
        chan_trip = '0;
        step();
        chk("R2 trip held", 8'(hiz), 8'h1);
        chan_rst_n[1] = 1'b0;
        step();
        chk("R1 other reset low", 8'(hiz), 8'h3);
        chan_rst_n[1] = 1'b1;
        step();
        chk("R3 other edge no clear", 8'(hiz), 8'h1);
        chk("R3 other edge fault_n", 8'(fault_n), 8'h0);
        chan_trip = 3'b001;
        pulse_rst(0);
        chk("R3 edge with request present", 8'(hiz), 8'h1);
        chan_trip = '0;
        pulse_rst(0);
        chk("R3 own edge clears hiz", 8'(hiz), 8'h0);
        chk("R3 own edge fault_n", 8'(fault_n), 8'h1);
    endtask

    task automatic t_latch();
        latch_mode = 1'b1;
        chan_trip  = 3'b010;
        step();
        chk("R4 latch all hiz", 8'(hiz), 8'h7);
        chk("R4 latch fault_n", 8'(fault_n), 8'h0);
        chan_trip = '0;
        pulse_rst(2);
        pulse_rst(0);
        chk("R5 two edges hold", 8'(hiz), 8'h7);
        pulse_rst(1);
        chk("R5 third edge clears", 8'(hiz), 8'h0);
        chk("R5 fault_n high", 8'(fault_n), 8'h1);
        latch_mode = 1'b0;
        step();
    endtask

    task automatic t_otp_edges();
        otp_trip = 1'b1;
        step();
        chk("R4 otp all hiz", 8'(hiz), 8'h7);
        pulse_rst(0); pulse_rst(1); pulse_rst(2);
        chk("R6 edges during otp ignored", 8'(hiz), 8'h7);
        otp_trip = 1'b0;
        step();
        chk("R6 still latched", 8'(fault_n), 8'h0);
        pulse_rst(0); pulse_rst(1);
        otp_trip = 1'b1;
        step();
        otp_trip = 1'b0;
        step();
        pulse_rst(2);
        chk("R6 mask discarded", 8'(hiz), 8'h7);
        pulse_rst(0);
        chk("R5 one missing", 8'(hiz), 8'h7);
        pulse_rst(1);
        chk("R5 cleared after full set", 8'(hiz), 8'h0);
        chk("R5 fault_n released", 8'(fault_n), 8'h1);
    endtask

    task automatic t_uv();
        uv_flag = 1'b1;
        #1 chk("R7 uv immediate hiz", 8'(hiz), 8'h7);
        chk("R7 fault_n not yet", 8'(fault_n), 8'h1);
        step();
        chk("R7 uv fault_n", 8'(fault_n), 8'h0);
        uv_flag = 1'b0;
        #1 chk("R7 uv release hiz", 8'(hiz), 8'h0);
        step();
        chk("R7 auto recover fault_n", 8'(fault_n), 8'h1);
    endtask

    task automatic t_por();
        otp_trip = 1'b1;
        step();
        otp_trip = 1'b0;
        chan_trip = 3'b100;
        step();
        chan_trip = '0;
        chk("R8 pre por fault", 8'(fault_n), 8'h0);
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        step();
        chk("R8 por clears hiz", 8'(hiz), 8'h0);
        chk("R8 por clears fault", 8'(fault_n), 8'h1);
    endtask

    initial begin
        #(CLK_PER * 200000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_rst_hiz();
        t_cbc();
        t_latch();
        t_otp_edges();
        t_uv();
        t_por();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule